// File: doc/BRIEF.md
# Staircase Gate Sequencer for a Hybrid Multilevel Inverter

This block drives the nine gate lines of an inverter that combines a four-switch polarity bridge with a chain of up to five series switches. Each switch in the chain adds one unit of voltage. Every clock-enabled step advances a position counter through one full output period. In the first half of the period the output climbs from zero to the peak and falls back to zero in positive polarity. The second half repeats the same staircase in negative polarity.

The chain is driven as a thermometer code: level k turns on the first k chain switches. The bridge selects the sign. Because of this, the chain completes two staircases per period while the bridge changes state only once per half. The `LEVELS_N` parameter sets the peak. The default of 5 gives the eleven-level form. A value of 2 gives the five-level form, in which the three upper chain lines stay off. A programmable step length sets how many clock cycles each level is held, which sets the fundamental frequency. The block also reports a signed copy of the current level, so that the level and the gate code can be checked against each other.

Top module: `stair_gate_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are all gates off (`bridge_g`=0, `chain_g`=0) and `level_o`=0. The step-length register loads `step_len` on that edge, and the position returns to the start of a positive half.
- R2: For a positive level k (1..N), `bridge_g`=4'b0101 (bit0 is the first upper-left switch, bit2 the lower-right switch of the positive pair) and `chain_g` bits 0..k-1 are 1 with the rest 0.
- R3: For a negative level -k, `bridge_g`=4'b1010 (bits 1 and 3 form the negative pair) and `chain_g` holds the same k-bit thermometer.
- R4: At level 0 in either half, `chain_g`=0 and `bridge_g`=4'b1010.
- R5: Each half visits the levels 0,1,..,N,..,1 in that order, with the sign of the half. The halves alternate and start positive. Each level lasts L clock cycles, where L is the latched step length (0 counts as 1). Outputs are registered and show the position held before the edge.
- R6: The two bridge pairs are never on together, and `level_o` never moves from positive to negative (or the reverse) without passing through 0.
- R7: A change on `step_len` takes effect only when the sequence wraps from the last step of a negative half into a new positive half, or on reset.
- R8: When `en` is low at an edge, the next outputs are all gates off and `level_o`=0, and the position and the step timer hold. When `en` returns, the sequence resumes where it stopped.
- R9: With `LEVELS_N`=2, `chain_g` bits 2..4 stay 0 and `level_o` stays within -2..+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low forces gates off and freezes the sequence |
| step_len | input | STEP_W | Clock cycles per level, sampled at period start |
| bridge_g | output | 4 | Bridge gate lines; bits 0 and 2 form the positive pair, bits 1 and 3 the negative pair |
| chain_g | output | 5 | Level chain gate lines, thermometer coded from bit 0 |
| level_o | output | 4 | Signed current output level in units |

## Verification
Two events can coincide in one cycle: the period wrap that latches a new step length, and a write to `step_len` or a drop of `en`. The bench provokes both on purpose. It watches its own reference position and, on the exact negedge before the wrap edge, changes `step_len`. At another point it pulls `en` low on the last cycle of a half. The behavioural model is judged on every clock for both the eleven-level and the five-level instances. A wrong latch point shows up as a misplaced level boundary. A wrong hold shows up as a skipped or repeated level after enable returns.

// File: rtl/stair_pkg.sv
package stair_pkg;
  localparam int CHAIN_MAX = 5;
  localparam int LEVEL_W   = 4;

  // Magnitude of the level at position idx inside one half of 2*n steps.
  function automatic int stair_mag(input int idx, input int n);
    return (idx <= n) ? idx : (2 * n - idx);
  endfunction

  // Thermometer code: the lowest mag chain lines on.
  function automatic logic [CHAIN_MAX-1:0] stair_chain(input int mag);
    logic [CHAIN_MAX-1:0] t;
    t = '0;
    for (int b = 0; b < CHAIN_MAX; b++) begin
      if (b < mag) t[b] = 1'b1;
    end
    return t;
  endfunction

  // Bridge pair: positive pair on bits 0/2, negative-or-zero pair on bits 1/3.
  function automatic logic [3:0] stair_bridge(input logic drive_pos);
    return drive_pos ? 4'b0101 : 4'b1010;
  endfunction
endpackage

// File: rtl/stair_step_timer.sv
module stair_step_timer #(
  parameter int STEP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [STEP_W-1:0] len,
  output logic              step_done
);
  logic [STEP_W-1:0] cnt;
  logic [STEP_W-1:0] last_cnt;

  assign last_cnt  = (len == '0) ? '0 : len - STEP_W'(1);
  assign step_done = run && (cnt == last_cnt);

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (step_done) cnt <= '0;
    else if (run)       cnt <= cnt + STEP_W'(1);
  end

  // R5: the dwell counter never runs past the latched step length
  assert_cnt_window_R5: assert property (@(posedge clk) disable iff (rst)
    cnt <= last_cnt);
endmodule

// File: rtl/stair_walker.sv
module stair_walker #(
  parameter int LEVELS_N = 5,
  parameter int STEP_W   = 16
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                step_done,
  input  logic [STEP_W-1:0]                   step_in,
  output logic [$clog2(2*LEVELS_N)-1:0]       idx,
  output logic                                neg_half,
  output logic [STEP_W-1:0]                   cur_len,
  output logic                                period_wrap
);
  localparam int IDX_W    = $clog2(2 * LEVELS_N);
  localparam int LAST_IDX = 2 * LEVELS_N - 1;

  logic half_end;

  assign half_end    = step_done && (idx == IDX_W'(LAST_IDX));
  assign period_wrap = half_end && neg_half;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx      <= '0;
      neg_half <= 1'b0;
      cur_len  <= step_in;
    end else if (step_done) begin
      idx <= half_end ? '0 : idx + IDX_W'(1);
      if (half_end)    neg_half <= ~neg_half;
      if (period_wrap) cur_len  <= step_in;
    end
  end

  // R5: position stays inside one half
  assert_idx_range_R5: assert property (@(posedge clk) disable iff (rst)
    int'(idx) <= LAST_IDX);
  // R7: the step length moves only on a period wrap
  assert_len_latch_R7: assert property (@(posedge clk) disable iff (rst)
    !period_wrap |=> cur_len == $past(cur_len));
  // R5: the half flips only at the end of its last step
  assert_half_flip_R5: assert property (@(posedge clk) disable iff (rst)
    !half_end |=> neg_half == $past(neg_half));
endmodule

// File: rtl/stair_gate_enc.sv
module stair_gate_enc
  import stair_pkg::*;
#(
  parameter int LEVELS_N = 5
) (
  input  logic [$clog2(2*LEVELS_N)-1:0] idx,
  input  logic                          neg_half,
  output logic [3:0]                    bridge_n,
  output logic [CHAIN_MAX-1:0]          chain_n,
  output logic signed [LEVEL_W-1:0]     level_n
);
  int                   mag;
  logic [CHAIN_MAX-1:0] therm;

  always_comb begin
    mag      = stair_mag(int'(idx), LEVELS_N);
    therm    = stair_chain(mag);
    bridge_n = stair_bridge(!neg_half && (mag != 0));
    level_n  = neg_half ? -LEVEL_W'(mag) : LEVEL_W'(mag);
  end

  for (genvar b = 0; b < CHAIN_MAX; b++) begin : g_chain
    if (b < LEVELS_N) begin : g_used
      assign chain_n[b] = therm[b];
    end else begin : g_tied
      assign chain_n[b] = 1'b0;
    end
  end
endmodule

// File: rtl/stair_gate_seq.sv
module stair_gate_seq
  import stair_pkg::*;
#(
  parameter int LEVELS_N = 5,
  parameter int STEP_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic [STEP_W-1:0]        step_len,
  output logic [3:0]               bridge_g,
  output logic [CHAIN_MAX-1:0]     chain_g,
  output logic signed [LEVEL_W-1:0] level_o
);
  localparam int IDX_W = $clog2(2 * LEVELS_N);

  logic                      step_done;
  logic [IDX_W-1:0]          idx;
  logic                      neg_half;
  logic [STEP_W-1:0]         cur_len;
  logic                      period_wrap;
  logic [3:0]                bridge_n;
  logic [CHAIN_MAX-1:0]      chain_n;
  logic signed [LEVEL_W-1:0] level_n;

  stair_step_timer #(.STEP_W(STEP_W)) timer_i (
    .clk(clk), .rst(rst), .run(en), .len(cur_len), .step_done(step_done));

  stair_walker #(.LEVELS_N(LEVELS_N), .STEP_W(STEP_W)) walker_i (
    .clk(clk), .rst(rst), .step_done(step_done), .step_in(step_len),
    .idx(idx), .neg_half(neg_half), .cur_len(cur_len), .period_wrap(period_wrap));

  stair_gate_enc #(.LEVELS_N(LEVELS_N)) enc_i (
    .idx(idx), .neg_half(neg_half),
    .bridge_n(bridge_n), .chain_n(chain_n), .level_n(level_n));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      bridge_g <= '0;
      chain_g  <= '0;
      level_o  <= '0;
    end else begin
      bridge_g <= bridge_n;
      chain_g  <= chain_n;
      level_o  <= level_n;
    end
  end

  // R6: the two bridge pairs never conduct together
  assert_bridge_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !((bridge_g[0] || bridge_g[2]) && (bridge_g[1] || bridge_g[3])));
  // R6: sign changes only through zero
  assert_no_sign_jump_R6: assert property (@(posedge clk) disable iff (rst)
    (level_o > 0) |=> (level_o >= 0));
  assert_no_sign_jump_neg_R6: assert property (@(posedge clk) disable iff (rst)
    (level_o < 0) |=> (level_o <= 0));
  // R2 and R3: number of chain lines on equals the level magnitude
  assert_chain_matches_level_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(chain_g) == int'(level_o < 0 ? -level_o : level_o));
  // R8: disabling turns every gate off on the next edge
  assert_disabled_off_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (bridge_g == '0 && chain_g == '0 && level_o == '0));
  // R5: while running, the level moves by at most one unit per clock
  assert_level_step_R5: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en)) |=> ((level_o - $past(level_o)) <= 1 && ($past(level_o) - level_o) <= 1));

  if (LEVELS_N < CHAIN_MAX) begin : g_reduced_chk
    // R9: unused chain lines stay off in the reduced form
    assert_reduced_chain_R9: assert property (@(posedge clk) disable iff (rst)
      chain_g[CHAIN_MAX-1:LEVELS_N] == '0);
  end
endmodule

// File: tb/stair_gate_seq_tb.sv
`timescale 1ns/1ps
module stair_gate_seq_tb_top;
  localparam int STEP_W = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              en  = 1'b0;
  logic [STEP_W-1:0] step_len = 16'd2;

  logic [3:0]        br0, br1;
  logic [4:0]        ch0, ch1;
  logic signed [3:0] lv0, lv1;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  stair_gate_seq #(.LEVELS_N(5), .STEP_W(STEP_W)) dut_i (
    .clk(clk), .rst(rst), .en(en), .step_len(step_len),
    .bridge_g(br0), .chain_g(ch0), .level_o(lv0));

  stair_gate_seq #(.LEVELS_N(2), .STEP_W(STEP_W)) dut2_i (
    .clk(clk), .rst(rst), .en(en), .step_len(step_len),
    .bridge_g(br1), .chain_g(ch1), .level_o(lv1));

  // Behavioural reference: position in a period of 4N steps, dwell count, latched length.
  int peak[2] = '{5, 2};
  int m_pos[2], m_cnt[2], m_len[2];
  int e_lvl[2], e_br[2], e_ch[2], e_mode[2];
  int prev_lvl[2] = '{0, 0};

  always @(posedge clk) begin
    for (int d = 0; d < 2; d++) begin
      if (rst) begin
        m_pos[d] = 0; m_cnt[d] = 0; m_len[d] = int'(step_len);
        e_lvl[d] = 0; e_br[d] = 0; e_ch[d] = 0; e_mode[d] = 0;
      end else if (!en) begin
        e_lvl[d] = 0; e_br[d] = 0; e_ch[d] = 0; e_mode[d] = 1;
      end else begin
        int half_len, i, mag, dwell;
        half_len = 2 * peak[d];
        i   = m_pos[d] % half_len;
        mag = (i > peak[d]) ? half_len - i : i;
        e_lvl[d]  = (m_pos[d] >= half_len) ? -mag : mag;
        e_br[d]   = (e_lvl[d] > 0) ? 5 : 10;
        e_ch[d]   = (1 << mag) - 1;
        e_mode[d] = 2;
        dwell = (m_len[d] == 0) ? 1 : m_len[d];
        if (m_cnt[d] + 1 >= dwell) begin
          m_cnt[d] = 0;
          m_pos[d] = (m_pos[d] + 1) % (4 * peak[d]);
          if (m_pos[d] == 0) m_len[d] = int'(step_len);
        end else begin
          m_cnt[d] = m_cnt[d] + 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (!done) begin
      for (int d = 0; d < 2; d++) begin
        int a_br, a_ch, a_lv;
        string tb_tag;
        a_br = (d == 0) ? int'(br0) : int'(br1);
        a_ch = (d == 0) ? int'(ch0) : int'(ch1);
        a_lv = (d == 0) ? int'(lv0) : int'(lv1);
        if (e_mode[d] == 0)      tb_tag = "R1 reset";
        else if (e_mode[d] == 1) tb_tag = "R8 disabled";
        else if (e_lvl[d] > 0)   tb_tag = "R2 positive";
        else if (e_lvl[d] < 0)   tb_tag = "R3 negative";
        else                     tb_tag = "R4 zero";
        check(a_br == e_br[d], {tb_tag, " bridge"}, a_br, e_br[d]);
        check(a_ch == e_ch[d], (d == 1) ? "R9 reduced chain" : {tb_tag, " chain"}, a_ch, e_ch[d]);
        check(a_lv == e_lvl[d], (m_len[d] != int'(step_len)) ? "R7 level (length change pending)" : "R5 level order",
              a_lv, e_lvl[d]);
        check(!(((a_br & 5) != 0) && ((a_br & 10) != 0)), "R6 bridge overlap", a_br, 0);
        check(!((prev_lvl[d] > 0 && a_lv < 0) || (prev_lvl[d] < 0 && a_lv > 0)),
              "R6 sign jump", a_lv, 0);
        prev_lvl[d] = a_lv;
      end
    end
  end

  function automatic int dwell0();
    return (m_len[0] == 0) ? 1 : m_len[0];
  endfunction

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    int lf;
    repeat (3) @(negedge clk);
    rst = 1'b0;                                   // R1 checked while en low
    repeat (2) @(negedge clk);
    en = 1'b1;
    repeat (100) @(negedge clk);                  // R5 with L=2
    step_len = 16'd5;                             // R7 mid-period change
    repeat (250) @(negedge clk);
    // Change step length exactly on the wrap edge (R7 coincidence).
    while (!(m_pos[0] == 19 && m_cnt[0] + 1 >= dwell0())) @(negedge clk);
    step_len = 16'd1;
    repeat (100) @(negedge clk);
    step_len = 16'd0;                             // R5: zero means one cycle
    repeat (60) @(negedge clk);
    step_len = 16'd3;
    repeat (80) @(negedge clk);
    // Drop enable on the last cycle of a half (R8 with half flip).
    while (!(m_pos[0] == 9 && m_cnt[0] + 1 >= dwell0())) @(negedge clk);
    en = 1'b0;
    repeat (3) @(negedge clk);
    en = 1'b1;
    repeat (60) @(negedge clk);
    lf = 32'h1d2c;
    for (int k = 0; k < 300; k++) begin           // R8 irregular enable
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      en = lf[0] | lf[3];
      @(negedge clk);
    end
    en = 1'b1;
    step_len = 16'd4;
    repeat (30) @(negedge clk);
    rst = 1'b1;                                   // R1 reset mid-run
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (200) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end
endmodule